// File: doc/BRIEF.md
# Multilevel Carrier-Comparison PWM Phase Limb

This block drives the gates of one phase limb of a multi-cell inverter. A single signed reference sample is compared against one triangular carrier per cell. Each comparison result commands one complementary switch pair. The upper switch is commanded when the reference is above that cell's carrier, and the lower switch is commanded otherwise. Every cell has its own dead-time stage, so the two gates of a pair never overlap.

All carriers come from one phase counter. Two carrier placements can be chosen while the block runs:

- **Stacked placement:** the carriers are in phase and each occupies its own slice of the reference range.
- **Shifted placement:** every carrier spans the whole range and is delayed by an equal fraction of the carrier period.

The reference is latched at each carrier trough (symmetric sampling), or at both trough and peak (asymmetric sampling). Carrier half-period, placement, sampling style and dead-time count are supplied as inputs. All of them take effect together at the next trough, so a carrier cycle is never cut short.

Throughout, P is the active half-period, C is the cell count and FS = 2^(RW-1) is the reference full scale.

Top module: `ml_carrier_pwm`

## Requirements
- R1: A phase counter runs from 0 to 2P-1 and then returns to 0; that return is the trough. The triangle value is the phase while the phase is at most P, and 2P minus the phase above P. It is 0 at the trough and P at the peak, and one carrier cycle lasts 2P clocks.
- R2: For each cell k, the command is upper when the latched reference is strictly greater than carrier k; otherwise the command is lower.
- R3: With shift_i=0 at the last trough (stacked placement), carrier k equals -FS + k·(2FS/C) + tri·(2FS/C)/P. All carriers use the same triangle value, so an upper command in cell k implies an upper command in every cell below k.
- R4: With shift_i=1 at the last trough (shifted placement), carrier k equals -FS + tri_k·2FS/P. Here tri_k is the triangle value of phase (phase + k·2P/C) mod 2P. P must be chosen so that 2P is a multiple of C.
- R5: With asym_i=0 at the last trough, the reference is taken from ref_i (two's complement) only on the clock edge that moves the phase to 0.
- R6: With asym_i=1 at the last trough, the reference is also taken on the clock edge that moves the phase to P.
- R7: period_i, dead_i, shift_i and asym_i are captured together only on a trough edge, and on the first clock edge after reset. Changes at any other time have no effect until the next trough.
- R8: When a cell's command changes, its active gate goes low on that edge. Both gates then stay low for dead+1 clocks before the newly commanded gate rises. A command that reverses during this window restarts the window.
- R9: gate_hi_o[k] and gate_lo_o[k] are never high together.
- R10: During reset, and on the first clock edge after reset (the load edge), all gates are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | RW | Signed reference sample |
| period_i | input | PW | Carrier half-period P in clocks (at least 1) |
| dead_i | input | DW | Dead-time count |
| shift_i | input | 1 | 1 = phase-shifted carriers, 0 = stacked carriers |
| asym_i | input | 1 | 1 = sample at trough and peak, 0 = sample at trough only |
| gate_hi_o | output | CELLS | Upper switch gates, one per cell |
| gate_lo_o | output | CELLS | Lower switch gates, one per cell |

## Verification
The following are checked on every cycle by properties:
- gate exclusivity in each pair;
- the minimum low gap before any gate rises, measured against the dead count captured when the gap began;
- the bound and step of the phase counter;
- configuration and reference registers changing only at trough or peak;
- the nested order of stacked-mode commands.

The exact carrier shapes, the quarter-period offsets of the shifted mode, the deferral of mid-cycle configuration changes, and the difference between the two sampling styles can only be shown by the bench. It sweeps placements, sampling styles, periods and dead times under random, ramped and full-scale references. At every cycle it compares all gates with values computed from the carrier formulas.

// File: rtl/mlcp_pkg.sv
package mlcp_pkg;
  typedef enum logic {CAR_STACKED = 1'b0, CAR_SHIFTED = 1'b1} car_mode_e;
  typedef enum logic {SAMP_SYM = 1'b0, SAMP_ASYM = 1'b1} samp_e;
endpackage

// File: rtl/mlcp_timebase.sv
module mlcp_timebase
  import mlcp_pkg::*;
#(
  parameter int RW      = 8,
  parameter int PW      = 8,
  parameter int DW      = 4,
  parameter int DEF_PER = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [RW-1:0]   ref_i,
  input  logic [PW-1:0]   period_i,
  input  logic [DW-1:0]   dead_i,
  input  logic            shift_i,
  input  logic            asym_i,
  output logic            run_o,
  output logic [PW:0]     ph_o,
  output logic [PW-1:0]   per_o,
  output logic [DW-1:0]   dead_o,
  output car_mode_e       mode_o,
  output logic [RW-1:0]   ref_o
);
  localparam int PHW = PW + 1;

  logic            init_q;
  logic [PHW-1:0]  ph_q;
  logic [PW-1:0]   per_q;
  logic [DW-1:0]   dead_q;
  car_mode_e       mode_q;
  samp_e           samp_q;
  logic [RW-1:0]   ref_q;
  logic [PHW-1:0]  per2;
  logic            wrap, peak_nxt;

  assign per2     = {per_q, 1'b0};
  assign wrap     = init_q || (ph_q == per2 - PHW'(1));
  assign peak_nxt = (ph_q == {1'b0, per_q} - PHW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b1;
      ph_q   <= '0;
      per_q  <= PW'(DEF_PER);
      dead_q <= '0;
      mode_q <= CAR_STACKED;
      samp_q <= SAMP_SYM;
      ref_q  <= '0;
    end else if (wrap) begin
      // trough: new cycle, new settings, new sample
      init_q <= 1'b0;
      ph_q   <= '0;
      per_q  <= period_i;
      dead_q <= dead_i;
      mode_q <= car_mode_e'(shift_i);
      samp_q <= samp_e'(asym_i);
      ref_q  <= ref_i;
    end else begin
      ph_q <= ph_q + PHW'(1);
      if (samp_q == SAMP_ASYM && peak_nxt) ref_q <= ref_i;
    end
  end

  assign run_o  = !init_q;
  assign ph_o   = ph_q;
  assign per_o  = per_q;
  assign dead_o = dead_q;
  assign mode_o = mode_q;
  assign ref_o  = ref_q;

  // R1
  ph_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q < per2);
  // R1
  ph_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q != '0) |-> (ph_q == $past(ph_q) + PHW'(1)));
  // R7
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(per_q) || !$stable(dead_q) || !$stable(mode_q) || !$stable(samp_q))
      |-> (ph_q == '0));
  // R5 R6
  ref_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ref_q) |-> ((ph_q == '0) || (samp_q == SAMP_ASYM && ph_q == {1'b0, per_q})));
endmodule

// File: rtl/mlcp_cell_cmp.sv
module mlcp_cell_cmp #(
  parameter int CELLS = 4,
  parameter int RW    = 8,
  parameter int PW    = 8,
  parameter int K     = 0
) (
  input  logic [RW-1:0] ref_i,
  input  logic [PW:0]   ph_i,
  input  logic [PW-1:0] per_i,
  input  logic          shift_i,
  output logic          cmd_o
);
  localparam int PHW  = PW + 1;
  localparam int LC   = $clog2(CELLS);
  localparam int FS   = 1 << (RW - 1);
  localparam int BAND = (1 << RW) >> LC;
  localparam int MW   = RW + PW + 4;
  localparam int QW   = PW + 2 + LC;

  logic [QW-1:0]         prod;
  logic [PHW-1:0]        off;
  logic [PHW:0]          sum, per2x;
  logic [PHW-1:0]        phk, tri_v;
  logic signed [MW-1:0]  diff, per_s, lhs, rhs;

  // phase lead of this cell: k/C of the full carrier cycle
  assign prod  = QW'({per_i, 1'b0}) * QW'(K);
  assign off   = shift_i ? PHW'(prod >> LC) : '0;
  assign sum   = {1'b0, ph_i} + {1'b0, off};
  assign per2x = {1'b0, per_i, 1'b0};
  assign phk   = (sum >= per2x) ? PHW'(sum - per2x) : PHW'(sum);
  assign tri_v = (phk <= {1'b0, per_i}) ? phk : PHW'({per_i, 1'b0} - phk);

  // ref > base + tri*span/P  <=>  (ref + FS - base_k)*P > tri*span
  assign diff  = MW'($signed(ref_i)) + MW'(FS) - (shift_i ? MW'(0) : MW'(K * BAND));
  assign per_s = $signed(MW'({1'b0, per_i}));
  assign lhs   = diff * per_s;
  assign rhs   = shift_i ? (MW'(tri_v) << RW) : (MW'(tri_v) << (RW - LC));
  assign cmd_o = lhs > rhs;
endmodule

// File: rtl/mlcp_deadband.sv
module mlcp_deadband #(
  parameter int DW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          cmd_i,
  input  logic [DW-1:0] dead_i,
  output logic          hi_o,
  output logic          lo_o
);
  logic          cur_q;
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= 1'b0;
      cnt_q <= '0;
      hi_o  <= 1'b0;
      lo_o  <= 1'b0;
    end else if (!en_i) begin
      cur_q <= 1'b0;
      cnt_q <= '0;
      hi_o  <= 1'b0;
      lo_o  <= 1'b0;
    end else if (cmd_i != cur_q) begin
      cur_q <= cmd_i;
      cnt_q <= dead_i;
      hi_o  <= 1'b0;
      lo_o  <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - DW'(1);
      hi_o  <= 1'b0;
      lo_o  <= 1'b0;
    end else begin
      hi_o <= cur_q;
      lo_o <= !cur_q;
    end
  end

  // gap observer: clocks with both gates low, and dead count at gap start
  logic [DW:0]   gap_q;
  logic [DW-1:0] dsnap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q   <= '0;
      dsnap_q <= '0;
    end else if (hi_o || lo_o) begin
      gap_q   <= '0;
      dsnap_q <= dead_i;
    end else if (gap_q != '1) begin
      gap_q <= gap_q + (DW+1)'(1);
    end
  end

  // R9
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hi_o && lo_o));
  // R8
  dead_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(hi_o) || $rose(lo_o)) |-> (gap_q > {1'b0, dsnap_q}));
endmodule

// File: rtl/ml_carrier_pwm.sv
module ml_carrier_pwm
  import mlcp_pkg::*;
#(
  parameter int CELLS   = 4,
  parameter int RW      = 8,
  parameter int PW      = 8,
  parameter int DW      = 4,
  parameter int DEF_PER = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RW-1:0]    ref_i,
  input  logic [PW-1:0]    period_i,
  input  logic [DW-1:0]    dead_i,
  input  logic             shift_i,
  input  logic             asym_i,
  output logic [CELLS-1:0] gate_hi_o,
  output logic [CELLS-1:0] gate_lo_o
);
  logic            run;
  logic [PW:0]     ph_q;
  logic [PW-1:0]   per_q;
  logic [DW-1:0]   dead_q;
  car_mode_e       mode_q;
  logic [RW-1:0]   ref_q;
  logic [CELLS-1:0] cmd;

  mlcp_timebase #(.RW(RW), .PW(PW), .DW(DW), .DEF_PER(DEF_PER)) u_tb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ref_i   (ref_i),
    .period_i(period_i),
    .dead_i  (dead_i),
    .shift_i (shift_i),
    .asym_i  (asym_i),
    .run_o   (run),
    .ph_o    (ph_q),
    .per_o   (per_q),
    .dead_o  (dead_q),
    .mode_o  (mode_q),
    .ref_o   (ref_q)
  );

  for (genvar k = 0; k < CELLS; k++) begin : g_cell
    mlcp_cell_cmp #(.CELLS(CELLS), .RW(RW), .PW(PW), .K(k)) u_cmp (
      .ref_i  (ref_q),
      .ph_i   (ph_q),
      .per_i  (per_q),
      .shift_i(mode_q == CAR_SHIFTED),
      .cmd_o  (cmd[k])
    );

    mlcp_deadband #(.DW(DW)) u_db (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (run),
      .cmd_i (cmd[k]),
      .dead_i(dead_q),
      .hi_o  (gate_hi_o[k]),
      .lo_o  (gate_lo_o[k])
    );

    if (k > 0) begin : g_ord
      // R3
      stack_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_q == CAR_STACKED && cmd[k]) |-> cmd[k-1]);
    end
  end

  // R10
  reset_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> (gate_hi_o == '0 && gate_lo_o == '0));
endmodule

// File: tb/sim_ml_carrier_pwm.sv
module sim_ml_carrier_pwm;
  localparam int CELLS = 4, RW = 8, PW = 8, DW = 4, DEF_PER = 16;
  localparam int FS = 1 << (RW - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [RW-1:0] ref_i = '0;
  logic [PW-1:0] per_i = PW'(8);
  logic [DW-1:0] dead_i = '0;
  logic shift_i = 1'b0, asym_i = 1'b0;
  logic [CELLS-1:0] hi, lo;

  always #4 clk = ~clk;

  ml_carrier_pwm #(.CELLS(CELLS), .RW(RW), .PW(PW), .DW(DW), .DEF_PER(DEF_PER)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_i), .period_i(per_i), .dead_i(dead_i),
    .shift_i(shift_i), .asym_i(asym_i), .gate_hi_o(hi), .gate_lo_o(lo));

  int n_chk = 0, n_bad = 0, n_cyc = 0;
  bit done = 1'b0;

  // expected-value model built from the requirement formulas
  bit m_init, m_mode, m_asym;
  int m_ph, m_per, m_dead, m_ref;
  bit m_cur [CELLS];
  int m_cnt [CELLS];
  logic [CELLS-1:0] e_hi, e_lo;

  function automatic bit exp_cmd(int k);
    int p2, off, base, span, ph, tv, u;
    p2 = 2 * m_per;
    u  = m_ref + FS;
    if (m_mode) begin off = (k * p2) / CELLS; base = 0; span = 2 * FS; end   // R4
    else begin off = 0; base = k * (2 * FS / CELLS); span = 2 * FS / CELLS; end // R3
    ph = (m_ph + off) % p2;
    tv = (ph <= m_per) ? ph : p2 - ph;          // R1
    return (u - base) * m_per > tv * span;      // R2
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_init = 1; m_ph = 0; m_per = DEF_PER; m_dead = 0; m_ref = 0; m_mode = 0; m_asym = 0;
      for (int k = 0; k < CELLS; k++) begin m_cur[k] = 0; m_cnt[k] = 0; e_hi[k] = 0; e_lo[k] = 0; end
    end else begin
      for (int k = 0; k < CELLS; k++) begin
        bit c;
        c = exp_cmd(k);
        if (m_init) begin m_cur[k] = 0; m_cnt[k] = 0; e_hi[k] = 0; e_lo[k] = 0; end
        else if (c != m_cur[k]) begin m_cur[k] = c; m_cnt[k] = m_dead; e_hi[k] = 0; e_lo[k] = 0; end // R8
        else if (m_cnt[k] != 0) begin m_cnt[k]--; e_hi[k] = 0; e_lo[k] = 0; end
        else begin e_hi[k] = m_cur[k]; e_lo[k] = !m_cur[k]; end
      end
      if (m_init || m_ph == 2 * m_per - 1) begin   // R7 load at trough
        m_init = 0; m_ph = 0; m_per = int'(per_i); m_dead = int'(dead_i);
        m_mode = shift_i; m_asym = asym_i; m_ref = int'($signed(ref_i));   // R5
      end else begin
        if (m_asym && m_ph == m_per - 1) m_ref = int'($signed(ref_i));    // R6
        m_ph++;
      end
    end
  end

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    string tag;
    @(negedge clk);
    tag = {m_mode ? "R4" : "R3", m_asym ? " R6" : " R5", " R1 R2 R7 R8"};
    check(hi === e_hi && lo === e_lo, tag, "gates {hi,lo}", int'({hi, lo}), int'({e_hi, e_lo}));
    check((hi & lo) == '0, "R9", "pair overlap", int'(hi & lo), 0);
  endtask

  logic [15:0] lf = 16'hACE1;

  // pat: 0 pseudo-random, 1 ramp, 2 negative full scale, 3 positive full scale
  task automatic run(bit sh, bit as, int per, int dd, int ncyc, int pat);
    shift_i = sh; asym_i = as; per_i = PW'(per); dead_i = DW'(dd);
    if (pat == 1) ref_i = RW'(-FS);
    if (pat == 2) ref_i = RW'(-FS);
    if (pat == 3) ref_i = RW'(FS - 1);
    for (int i = 0; i < ncyc; i++) begin
      tick();
      if (pat == 0) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        ref_i = lf[RW-1:0];
      end else if (pat == 1) begin
        ref_i = ref_i + RW'(1);
      end
    end
  endtask

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog: actual=%0d cycles expected<=%0d", n_cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 gates idle while reset is held
    check(hi == '0 && lo == '0, "R10", "gates in reset", int'({hi, lo}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 load edge keeps gates low
    check(hi == '0 && lo == '0, "R10", "gates after load edge", int'({hi, lo}), 0);
    // sweep placement x sampling x period x dead, random references
    for (int c = 0; c < 16; c++) begin
      int per;
      per = c[2] ? 10 : 6;
      run(c[0], c[1], per, c[3] ? 3 : 0, 8 * per + 7, 0);
    end
    // ramp across the full reference range, both placements
    run(1'b0, 1'b0, 8, 1, 256, 1);
    run(1'b1, 1'b1, 8, 1, 256, 1);
    // full-scale extremes
    run(1'b0, 1'b0, 4, 0, 40, 2);
    run(1'b0, 1'b1, 4, 0, 40, 3);
    run(1'b1, 1'b0, 4, 2, 40, 2);
    run(1'b1, 1'b1, 4, 2, 40, 3);
    // dead count longer than half a carrier cycle: reversals during the window
    run(1'b0, 1'b1, 4, 9, 200, 0);
    run(1'b1, 1'b0, 2, 5, 120, 0);
    // long period, mid-cycle setting changes deferred
    run(1'b1, 1'b1, 32, 4, 90, 0);
    run(1'b0, 1'b0, 12, 0, 150, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule